// File: doc/BRIEF.md
# Video Line Lock Qualifier

This block turns raw, noisy indications that a video signal is being tracked into one stable lock flag. It applies hysteresis that is counted in video lines. A per-line strobe marks each line. On each strobe the block evaluates one lock condition and uses it to advance or restart a run counter. The lock flag is set only after the condition has held for a programmed number of consecutive lines. It is cleared only after the condition has failed for a separate programmed number of consecutive lines.

The lock condition comes from one of two raw sources, chosen by a configuration bit. The first is a slow indication that looks at the video over several fields. The second is a fast line-by-line horizontal-sync window check. A second bit can also require the colour subcarrier loop to be locked. The two thresholds are 3-bit codes. A non-linear table maps each code to a line count between 1 and 100000. All four settings sit in one 8-bit configuration register that is written through a write strobe. A one-cycle pulse marks every change of the lock flag.

Top module: `vlq_top`

## Requirements
- R1: After reset the lock flag and the change pulse are 0. The configuration register holds 0x90, which means both threshold codes are 100 (100 lines), source select is 0 and subcarrier requirement is 0.
- R2: The configuration byte has these fields: bit 0 is the subcarrier requirement, bit 1 is the source select, bits [4:2] are the enter code and bits [7:5] are the leave code. A write takes effect from the next clock.
- R3: Both codes use the same table: 000=1, 001=2, 010=5, 011=10, 100=100, 101=500, 110=1000, 111=100000 lines.
- R4: When unlocked, the flag is set on the strobe that completes the programmed number of consecutive lines with the condition true. Any strobe with the condition false restarts the count.
- R5: When locked, the flag is cleared on the strobe that completes the leave count of consecutive lines with the condition false. Any strobe with the condition true restarts the count.
- R6: Cycles without a strobe change neither the flag nor the count.
- R7: With source select 0 the condition follows the slow multi-field input. With source select 1 it follows the fast horizontal window input. The input that is not selected has no effect.
- R8: With the subcarrier requirement at 0, the subcarrier input has no effect. With it at 1, the condition also needs the subcarrier lock input to be high.
- R9: A threshold change in the middle of a count applies from the next strobe and does not clear the count. If the count already meets the new threshold, the flag toggles on that strobe.
- R10: The change pulse is high for exactly the one cycle in which the flag has just toggled, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe per video line |
| hwin_raw | input | 1 | Fast horizontal-sync window lock indication |
| frun_raw | input | 1 | Slow multi-field lock indication |
| sc_lock | input | 1 | Colour subcarrier lock indication |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration byte |
| lock_q | output | 1 | Qualified lock flag |
| lock_chg | output | 1 | One-cycle pulse on each lock flag change |

## Verification
The case that is hardest to reach from the ports is the largest code, 100000 lines. It can only be shown by keeping the condition true for the full run, and that run has to fit inside the cycle budget. The bench therefore drives one strobe on every clock for that stretch, and it compares the flag after every line, including lines 99999 and 100000. The threshold change in the middle of a count is reached by stopping a 10-line run at 7 lines, rewriting the enter code to 5, and expecting the lock on the very next strobe.

// File: rtl/vlq_pkg.sv
// Package: shared widths and the threshold code table for the lock qualifier.
// Assumes the largest programmable count (100000) fits in CNT_W bits.
package vlq_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 17;

    // Map a 3-bit threshold code to its line count.
    function automatic logic [CNT_W-1:0] code_to_lines(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'd0:    n = CNT_W'(1);
            3'd1:    n = CNT_W'(2);
            3'd2:    n = CNT_W'(5);
            3'd3:    n = CNT_W'(10);
            3'd4:    n = CNT_W'(100);
            3'd5:    n = CNT_W'(500);
            3'd6:    n = CNT_W'(1000);
            default: n = CNT_W'(100000);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/vlq_cfg_reg.sv
// Module: configuration register of the qualifier.
// Holds the enter and leave codes, the source select and the subcarrier requirement.
// Assumes a write takes effect from the next clock edge.
module vlq_cfg_reg #(
    parameter logic [7:0] RESET_VAL = 8'h90
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [7:0]                wdata,
    output logic [vlq_pkg::CODE_W-1:0] enter_code,
    output logic [vlq_pkg::CODE_W-1:0] leave_code,
    output logic                      src_fast,
    output logic                      sc_req
);
    logic [7:0] reg_q;

    // Store the configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)  reg_q <= RESET_VAL;
        else if (we) reg_q <= wdata;
    end

    // Split the byte into its fields.
    always_comb begin
        sc_req     = reg_q[0];
        src_fast   = reg_q[1];
        enter_code = reg_q[4:2];
        leave_code = reg_q[7:5];
    end
endmodule

// File: rtl/vlq_cond.sv
// Module: forms the per-line lock condition from the raw indications.
// Purely combinational. The caller samples it only on the line strobe.
module vlq_cond (
    input  logic hwin_raw,
    input  logic frun_raw,
    input  logic sc_lock,
    input  logic src_fast,
    input  logic sc_req,
    output logic cond_ok
);
    // Pick the raw source, then add the optional subcarrier term.
    always_comb begin
        cond_ok = (src_fast ? hwin_raw : frun_raw) & (sc_lock | ~sc_req);
    end
endmodule

// File: rtl/vlq_hyst.sv
// Module: line-counted hysteresis state machine.
// Counts consecutive strobes whose condition points away from the current state.
// The flag toggles when that run reaches the active threshold.
// Assumes the thresholds are at least 1 and fit in CNT_W bits.
module vlq_hyst #(
    parameter int CNT_W = vlq_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             cond_ok,
    input  logic [CNT_W-1:0] thr_enter,
    input  logic [CNT_W-1:0] thr_leave,
    output logic             lock_q,
    output logic             lock_chg
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] thr;
    logic             toward;

    // Select the threshold and the direction that counts for the current state.
    always_comb begin
        thr     = lock_q ? thr_leave : thr_enter;
        toward  = lock_q ? ~cond_ok  : cond_ok;
        cnt_inc = {1'b0, cnt_q} + 1'b1;
    end

    // Advance, restart or complete the run on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lock_q   <= 1'b0;
            lock_chg <= 1'b0;
        end else begin
            lock_chg <= 1'b0;
            if (line_stb) begin
                if (!toward) begin
                    cnt_q <= '0;
                end else if (cnt_inc >= {1'b0, thr}) begin
                    cnt_q    <= '0;
                    lock_q   <= ~lock_q;
                    lock_chg <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/vlq_top.sv
// Module: video line lock qualifier top.
// Ties together the configuration register, the condition select and the hysteresis counter.
// Assumes line_stb is high for one clock per video line, or on every clock for back-to-back lines.
module vlq_top (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       hwin_raw,
    input  logic       frun_raw,
    input  logic       sc_lock,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic       lock_q,
    output logic       lock_chg
);
    import vlq_pkg::*;

    logic [CODE_W-1:0] enter_code, leave_code;
    logic              src_fast, sc_req, cond_ok;
    logic [CNT_W-1:0]  thr_enter, thr_leave;

    vlq_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .enter_code(enter_code), .leave_code(leave_code),
        .src_fast(src_fast), .sc_req(sc_req)
    );

    vlq_cond u_cond (
        .hwin_raw(hwin_raw), .frun_raw(frun_raw), .sc_lock(sc_lock),
        .src_fast(src_fast), .sc_req(sc_req), .cond_ok(cond_ok)
    );

    // Decode both threshold codes through the shared table.
    always_comb begin
        thr_enter = code_to_lines(enter_code);
        thr_leave = code_to_lines(leave_code);
    end

    vlq_hyst #(.CNT_W(CNT_W)) u_hyst (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cond_ok(cond_ok),
        .thr_enter(thr_enter), .thr_leave(thr_leave),
        .lock_q(lock_q), .lock_chg(lock_chg)
    );
endmodule

// File: rtl/vlq_chk.sv
// Module: property checker for vlq_top, attached with the bind below.
module vlq_chk (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       line_stb,
    input logic                       lock_q,
    input logic                       lock_chg,
    input logic [vlq_pkg::CNT_W-1:0]  cnt
);
    // R10: the pulse marks exactly the cycles in which the flag has just changed
    a_r10_chg_matches_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        lock_chg == (lock_q != $past(lock_q)));

    // R6: no strobe, no flag change
    a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(lock_q));

    // R6: no strobe, no count change
    a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(cnt));

    // R3: the run counter never passes the largest table entry
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < 17'd100000);

    // R4: the lock flag rises only on a strobe
    a_r4_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(line_stb));

    // R5: the lock flag falls only on a strobe
    a_r5_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(line_stb));
endmodule

bind vlq_top vlq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
    .lock_q(lock_q), .lock_chg(lock_chg), .cnt(u_hyst.cnt_q)
);

// File: tb/vlq_top_tb_top.sv
// Scoreboard bench: line() predicts each strobe's result and queues it, and the monitor compares.
module vlq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0, hwin_raw = 1'b0, frun_raw = 1'b0, sc_lock = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       lock_q, lock_chg;

    typedef struct { bit lock; bit chg; string req; } exp_t;
    exp_t exp_q[$];

    int  n_vec = 0, n_bad = 0;
    bit  exp_lock = 0;
    int  exp_cnt = 0;
    bit [7:0] cfg_m = 8'h90;
    string cur_req = "R4";
    bit  done = 0;

    always #5 clk = ~clk;

    vlq_top dut_i (.*);

    function automatic int lines_of(bit [2:0] c);
        case (c)
            3'd0: return 1;      3'd1: return 2;
            3'd2: return 5;      3'd3: return 10;
            3'd4: return 100;    3'd5: return 500;
            3'd6: return 1000;   default: return 100000;
        endcase
    endfunction

    task automatic check(string req, bit act, bit expv, string what);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, expv, $time);
        end
    endtask

    // Apply one strobed line and queue its predicted result.
    task automatic line(bit hw, bit fr, bit sc);
        bit cond, toward, chg;
        @(negedge clk);
        hwin_raw = hw; frun_raw = fr; sc_lock = sc; line_stb = 1'b1;
        cond   = (cfg_m[1] ? hw : fr) && (cfg_m[0] ? sc : 1'b1);
        toward = exp_lock ? !cond : cond;
        chg    = 0;
        if (!toward) exp_cnt = 0;
        else if (exp_cnt + 1 >= lines_of(exp_lock ? cfg_m[7:5] : cfg_m[4:2])) begin
            exp_cnt = 0; exp_lock = !exp_lock; chg = 1;
        end else exp_cnt++;
        exp_q.push_back('{lock: exp_lock, chg: chg, req: cur_req});
    endtask

    task automatic lines(int n, bit hw, bit fr, bit sc);
        for (int i = 0; i < n; i++) line(hw, fr, sc);
    endtask

    // Idle cycles: no strobe, and the raw inputs toggle so that any leak would show.
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_stb = 1'b0; cfg_we = 1'b0;
            hwin_raw = ~hwin_raw; frun_raw = ~frun_raw; sc_lock = ~sc_lock;
        end
    endtask

    task automatic write_cfg(bit [7:0] v);
        @(negedge clk);
        line_stb = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
        cfg_m = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: compare after each edge; a non-strobe edge must leave the flag alone.
    always @(posedge clk) begin
        bit stb_now;
        stb_now = line_stb;
        if (rst_n) begin
            #2;
            if (stb_now) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R4 strobe seen with empty queue actual=1 expected=0");
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, lock_q, e.lock, "lock_q");
                    check("R10", lock_chg, e.chg, "lock_chg");
                end
            end else begin
                check("R6", lock_q, exp_lock, "lock_q idle");
                check("R10", lock_chg, 1'b0, "lock_chg idle");
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", lock_q, 1'b0, "reset lock");
        check("R1", lock_chg, 1'b0, "reset pulse");
        rst_n = 1'b1;
        idle(2);
        // R1, R3, R4: the default enter code is 100 lines (slow source, sc=0 ignored per R8)
        cur_req = "R4"; lines(100, 0, 1, 0); idle(3);
        // R5: 99 bad lines, one good line restarts, then 100 bad lines unlock
        cur_req = "R5"; lines(99, 0, 0, 0); line(0, 1, 0); lines(100, 0, 0, 0); idle(2);
        // R2, R3: code 000 gives one line each way
        cur_req = "R3"; write_cfg(8'h00); line(0, 1, 0); line(0, 0, 0); idle(2);
        // R4 restart, with enter code 010 = 5 and leave code 001 = 2
        cur_req = "R4"; write_cfg(8'h28); lines(4, 0, 1, 0); line(0, 0, 0); lines(5, 0, 1, 0); idle(2);
        cur_req = "R5"; line(0, 0, 0); line(0, 1, 0); lines(2, 0, 0, 0); idle(2);
        // R7: fast source selected, the slow input is ignored
        cur_req = "R7"; write_cfg(8'h2A); lines(5, 1, 0, 0); lines(2, 0, 1, 0); idle(2);
        // R8: subcarrier required
        cur_req = "R8"; write_cfg(8'h2B); lines(5, 1, 1, 0); lines(5, 1, 1, 1); lines(2, 1, 1, 0); idle(2);
        // R9: threshold lowered from 10 to 5 after 7 good lines locks on the next strobe
        cur_req = "R9"; write_cfg(8'h2C); lines(7, 0, 1, 0); write_cfg(8'h28); line(0, 1, 0);
        lines(2, 0, 0, 0); idle(2);
        // R3: codes 101 (500) to enter and 110 (1000) to leave
        cur_req = "R3"; write_cfg(8'hD4); lines(500, 0, 1, 0); lines(1000, 0, 0, 0); idle(2);
        // R3: code 111 = 100000 lines, strobed on every clock
        cur_req = "R3"; write_cfg(8'h1C); lines(100000, 0, 1, 0); idle(3);
        done = 1;
        finish_run();
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule